// File: doc/BRIEF.md
# Sparse Paged Memory with Lazy Frame Allocation

This block is a single-port word memory whose logical address range is larger than the storage behind it. The logical space is cut into pages of 256 words. The low eight address bits pick a word inside a page, and the upper bits name the logical page. A small pool of physical page frames backs the live pages. A fully-associative directory, searched in parallel on every access, records which logical page each frame holds. A frame is claimed only when a word of a page that has no frame is first written. Reads never claim anything.

Each stored word has its own written flag. A read of a word that has not been written since reset or the last flush raises no valid flag, and the data bus is driven unknown. A write that needs a new frame while the pool is exhausted is dropped and sets a sticky overflow flag. A flush request releases every frame, clears every written flag and clears the overflow flag. A flush beats a write in the same cycle.

Writes and flushes take effect on the rising clock edge. Reads are combinational from the address, so data appears in the same cycle.

Top module: `spm_sparse_mem`

## Requirements
- R1: With `rnw` low and `flush` low, `wdata` is stored at `addr` on the rising edge. From the next cycle, a read (`rnw` high) of that address returns the word in the same cycle with `rd_valid` high.
- R2: `addr[7:0]` selects the word within a page and `addr[ADDR_W-1:8]` is the logical page number. Words that differ in any address bit are stored independently.
- R3: A read of a word that has not been written since reset or the last flush gives `rd_valid` low, with `rdata` driven unknown. Reads never claim a frame: after reads of every address, all `FRAMES` frames remain available.
- R4: Inside a page that holds a frame, words that were never written still read with `rd_valid` low.
- R5: Up to `FRAMES` arbitrary, non-adjacent logical pages can be live at the same time, and each keeps its own contents.
- R6: A write to an unmapped page while all frames are in use is dropped. The word reads invalid afterwards, the other pages are unchanged, and `overflow` goes high on the next cycle.
- R7: Once high, `overflow` stays high until a flush. While the pool is full, writes to pages that already hold a frame still succeed.
- R8: A cycle with `flush` high makes every address read with `rd_valid` low from the next cycle. It also clears `overflow` and returns all `FRAMES` frames to the pool.
- R9: When `flush` and a write (`rnw` low) occur in the same cycle, the flush takes effect and the write is discarded.
- R10: After reset, every address reads with `rd_valid` low and `overflow` is low.
- R11: While `rnw` is low, `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and flushes act on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Logical word address (page number above bit 7, word below) |
| wdata | input | DATA_W | Word to store when `rnw` is low |
| rnw | input | 1 | High selects a read, low selects a write |
| flush | input | 1 | Release all frames and forget all contents |
| rdata | output | DATA_W | Combinational read data; unknown when `rd_valid` is low |
| rd_valid | output | 1 | High when a read hits a written word |
| overflow | output | 1 | Sticky flag: a write was dropped for lack of a frame |

## Verification
The hardest state to reach is a full frame pool in which some live pages are only partly written, combined with a dropped write. In that state the drop must leave the mapped pages untouched, and later writes to mapped pages must still land. The bench gets there by filling two non-adjacent pages, one completely and one on even words only, then writing single words into two more pages. It then attempts a fifth page, and after that sweeps every address against an arithmetic model. A flush is then issued in the same cycle as a write, to show that the flush wins. After this the pool is refilled with a new set of pages.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FLUSH = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/spm_req_decode.sv
module spm_req_decode #(
    parameter int ADDR_W  = 12,
    parameter int WORD_W  = 8,
    localparam int LPAGE_W = ADDR_W - WORD_W
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rnw,
    input  logic               flush,
    output logic [LPAGE_W-1:0] lpage,
    output logic [WORD_W-1:0]  word,
    output spm_pkg::acc_kind_e kind
);
    import spm_pkg::*;

    assign lpage = addr[ADDR_W-1:WORD_W];
    assign word  = addr[WORD_W-1:0];

    always_comb begin
        if (flush) begin
            kind = ACC_FLUSH;
        end else if (!rnw) begin
            kind = ACC_WRITE;
        end else begin
            kind = ACC_READ;
        end
    end

endmodule

// File: rtl/spm_page_dir.sv
module spm_page_dir #(
    parameter int LPAGE_W = 4,
    parameter int FRAMES  = 4,
    localparam int FIDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LPAGE_W-1:0] lpage,
    input  logic               wr_req,
    input  logic               flush,
    output logic [FRAMES-1:0]  hit_vec,
    output logic               hit,
    output logic               full,
    output logic [FIDX_W-1:0]  frame_idx
);

    typedef struct packed {
        logic [FRAMES-1:0]              live;
        logic [FRAMES-1:0][LPAGE_W-1:0] tag;
    } dir_state_t;

    dir_state_t st_d, st_q;
    logic [FIDX_W-1:0] hit_idx;
    logic [FIDX_W-1:0] free_idx;
    logic              claim;

    // parallel tag compare, one comparator per frame
    for (genvar g = 0; g < FRAMES; g++) begin : g_cmp
        assign hit_vec[g] = st_q.live[g] && (st_q.tag[g] == lpage);
    end

    assign hit  = |hit_vec;
    assign full = &st_q.live;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < FRAMES; i++) begin
            if (hit_vec[i]) begin
                hit_idx = FIDX_W'(i);
            end
        end
    end

    // lowest-numbered free frame is handed out first
    always_comb begin
        free_idx = '0;
        for (int i = FRAMES - 1; i >= 0; i--) begin
            if (!st_q.live[i]) begin
                free_idx = FIDX_W'(i);
            end
        end
    end

    assign claim     = wr_req && !flush && !hit && !full;
    assign frame_idx = hit ? hit_idx : free_idx;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.live = '0;
        end else if (claim) begin
            st_d.live[free_idx] = 1'b1;
            st_d.tag[free_idx]  = lpage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/spm_frame_store.sv
module spm_frame_store #(
    parameter int DATA_W = 16,
    parameter int WORD_W = 8,
    parameter int FRAMES = 4,
    localparam int FIDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
    localparam int DEPTH  = 1 << WORD_W,
    localparam int NSLOT  = FRAMES * DEPTH,
    localparam int SLOT_W = FIDX_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [FIDX_W-1:0] frame_idx,
    input  logic [WORD_W-1:0] word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid
);

    typedef struct packed {
        logic [NSLOT-1:0] written;
    } store_state_t;

    store_state_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [NSLOT];
    logic [SLOT_W-1:0] slot;

    assign slot = {frame_idx, word};

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.written = '0;
        end else if (wr_en) begin
            st_d.written[slot] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // data words need no reset: the written flags gate every read
    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            mem_q[slot] <= wdata;
        end
    end

    assign rd_valid = rd_en && st_q.written[slot];
    assign rdata    = rd_valid ? mem_q[slot] : {DATA_W{1'bx}};

endmodule

// File: rtl/spm_sparse_mem.sv
module spm_sparse_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int WORD_W = 8,
    parameter int FRAMES = 4,
    localparam int LPAGE_W = ADDR_W - WORD_W,
    localparam int FIDX_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rnw,
    input  logic              flush,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              overflow
);
    import spm_pkg::*;

    typedef struct packed {
        logic ovf;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [LPAGE_W-1:0] lpage;
    logic [WORD_W-1:0]  word;
    acc_kind_e          kind;
    logic [FRAMES-1:0]  dir_hit_vec;
    logic               dir_hit;
    logic               dir_full;
    logic [FIDX_W-1:0]  frame_idx;
    logic               is_wr;
    logic               is_rd;
    logic               is_flush;
    logic               store_wr;

    spm_req_decode #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_dec (
        .addr  (addr),
        .rnw   (rnw),
        .flush (flush),
        .lpage (lpage),
        .word  (word),
        .kind  (kind)
    );

    assign is_wr    = (kind == ACC_WRITE);
    assign is_rd    = (kind == ACC_READ);
    assign is_flush = (kind == ACC_FLUSH);

    spm_page_dir #(
        .LPAGE_W (LPAGE_W),
        .FRAMES  (FRAMES)
    ) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .lpage     (lpage),
        .wr_req    (is_wr),
        .flush     (is_flush),
        .hit_vec   (dir_hit_vec),
        .hit       (dir_hit),
        .full      (dir_full),
        .frame_idx (frame_idx)
    );

    assign store_wr = is_wr && (dir_hit || !dir_full);

    spm_frame_store #(
        .DATA_W (DATA_W),
        .WORD_W (WORD_W),
        .FRAMES (FRAMES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (is_flush),
        .wr_en     (store_wr),
        .rd_en     (is_rd && dir_hit),
        .frame_idx (frame_idx),
        .word      (word),
        .wdata     (wdata),
        .rdata     (rdata),
        .rd_valid  (rd_valid)
    );

    always_comb begin
        st_d = st_q;
        if (is_flush) begin
            st_d.ovf = 1'b0;
        end else if (is_wr && !dir_hit && dir_full) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign overflow = st_q.ovf;

endmodule

// File: rtl/spm_sparse_mem_chk.sv
module spm_sparse_mem_chk #(
    parameter int ADDR_W = 12,
    parameter int FRAMES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rnw,
    input logic              flush,
    input logic              rd_valid,
    input logic              overflow,
    input logic [FRAMES-1:0] hit_vec,
    input logic              full
);

    // R11
    assert_no_valid_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rnw |-> !rd_valid);

    // R7
    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);

    // R8
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!overflow && !rd_valid));

    // R9
    assert_flush_beats_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !rnw) |=> !rd_valid);

    // R6
    assert_overflow_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> ($past(!rnw) && $past(!flush)));

    // R2
    assert_single_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R1
    assert_write_then_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rnw && !flush && ((|hit_vec) || !full))
        |=> (!(rnw && !flush && addr == $past(addr)) || rd_valid));

endmodule

bind spm_sparse_mem spm_sparse_mem_chk #(
    .ADDR_W (ADDR_W),
    .FRAMES (FRAMES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .rnw      (rnw),
    .flush    (flush),
    .rd_valid (rd_valid),
    .overflow (overflow),
    .hit_vec  (dir_hit_vec),
    .full     (dir_full)
);

// File: tb/spm_sparse_mem_tb.sv
module spm_sparse_mem_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int WORD_W = 8;
    localparam int FRAMES = 4;
    localparam int NADDR  = 1 << ADDR_W;
    localparam int NPAGE  = 1 << (ADDR_W - WORD_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              rnw = 1'b1;
    logic              flush = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic              rd_valid;
    logic              overflow;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [DATA_W-1:0] m_data [NADDR];
    bit                m_wr   [NADDR];
    bit                pg_live[NPAGE];
    int                live_cnt;
    bit                exp_ovf;

    spm_sparse_mem #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .FRAMES (FRAMES)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wdata    (wdata),
        .rnw      (rnw),
        .flush    (flush),
        .rdata    (rdata),
        .rd_valid (rd_valid),
        .overflow (overflow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [DATA_W-1:0] dval(input int a, input int seed);
        return DATA_W'((a * 40503 + seed * 7919) ^ 16'h5A5A);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NADDR; i++) m_wr[i] = 0;
        for (int p = 0; p < NPAGE; p++) pg_live[p] = 0;
        live_cnt = 0;
        exp_ovf  = 0;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // single write; rd_valid is observed low while rnw is low (R11)
    task automatic wr(input int a, input logic [DATA_W-1:0] d);
        int lp;
        @(negedge clk);
        addr = ADDR_W'(a); wdata = d; rnw = 1'b0; flush = 1'b0;
        #1;
        check(rd_valid == 1'b0, "R11 rd_valid during write", int'(rd_valid), 0);
        @(posedge clk);
        lp = a >> WORD_W;
        if (!pg_live[lp]) begin
            if (live_cnt < FRAMES) begin
                pg_live[lp] = 1;
                live_cnt++;
            end else begin
                exp_ovf = 1;
            end
        end
        if (pg_live[lp]) begin
            m_data[a] = d;
            m_wr[a]   = 1;
        end
        @(negedge clk);
        rnw = 1'b1;
    endtask

    task automatic rd_chk(input int a, input string req);
        @(negedge clk);
        addr = ADDR_W'(a); rnw = 1'b1; flush = 1'b0;
        #1;
        check(rd_valid == m_wr[a], req, int'(rd_valid), int'(m_wr[a]));
        if (m_wr[a] && rd_valid) begin
            check(rdata == m_data[a], req, int'(rdata), int'(m_data[a]));
        end
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < NADDR; a++) rd_chk(a, req);
    endtask

    task automatic ovf_chk(input string req);
        @(negedge clk);
        #1;
        check(overflow == exp_ovf, req, int'(overflow), int'(exp_ovf));
    endtask

    task automatic do_flush(input bit with_write, input int a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        flush = 1'b1; rnw = !with_write; addr = ADDR_W'(a); wdata = d;
        @(posedge clk);
        model_clear();
        @(negedge clk);
        flush = 1'b0; rnw = 1'b1;
    endtask

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        ovf_chk("R10 overflow after reset");
        sweep("R10 R3 unwritten after reset");

        // R3: reads claimed nothing, so four pages still fit below
        // R5 R4 R2: full page 3, even words of page 9 (non-adjacent)
        for (int w = 0; w < 256; w++) wr(3 * 256 + w, dval(3 * 256 + w, 1));
        for (int w = 0; w < 256; w += 2) wr(9 * 256 + w, dval(9 * 256 + w, 1));
        sweep("R1 R2 R4 two pages");
        wr(14 * 256 + 200, dval(14 * 256 + 200, 1));
        wr(0 * 256 + 17, dval(17, 1));
        ovf_chk("R5 R3 four pages no overflow");
        rd_chk(14 * 256 + 200, "R5 page 14 word");
        rd_chk(14 * 256 + 201, "R4 page 14 neighbour");

        // R6: fifth page dropped
        wr(7 * 256 + 5, dval(7 * 256 + 5, 2));
        ovf_chk("R6 overflow set");
        rd_chk(7 * 256 + 5, "R6 dropped word invalid");
        // R7: mapped page still writable when full; flag sticky
        wr(9 * 256 + 1, dval(9 * 256 + 1, 3));
        wr(3 * 256 + 0, dval(3 * 256, 3));
        rd_chk(9 * 256 + 1, "R7 write to mapped page while full");
        repeat (5) @(posedge clk);
        ovf_chk("R7 overflow sticky");
        sweep("R6 R7 full pool contents");

        // R9: flush with simultaneous write; R8: everything forgotten
        do_flush(1'b1, 3 * 256 + 5, 16'hBEEF);
        rd_chk(3 * 256 + 5, "R9 write discarded by flush");
        ovf_chk("R8 overflow cleared");
        sweep("R8 all invalid after flush");

        // R8: pool fully available again
        wr(1 * 256 + 0, dval(256, 4));
        wr(2 * 256 + 255, dval(2 * 256 + 255, 4));
        wr(5 * 256 + 128, dval(5 * 256 + 128, 4));
        wr(15 * 256 + 77, dval(15 * 256 + 77, 4));
        ovf_chk("R8 four pages after flush");
        sweep("R8 R2 refilled pool");
        wr(6 * 256 + 1, dval(6 * 256 + 1, 5));
        ovf_chk("R6 overflow again");

        // R10: reset from busy state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        ovf_chk("R10 overflow after second reset");
        sweep("R10 invalid after second reset");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule